// File: doc/BRIEF.md
# Flash Read Prefetch Line Buffer

This block sits between a system bus read port and a slow flash array that returns 128 bits per access. It keeps four fully associative 16-byte lines. A read that finds its line returns a 32-bit word in the same cycle. A read that finds nothing starts one wide flash access. A programmable wait-state count times that access, and the fetched line is then written into a line slot chosen by the kind of requester.

A single-line prefetch buffer can be enabled per requester kind. After a line is filled, the next 16-byte aligned line is fetched into the buffer. A later read of that line moves the buffer into a line slot and returns the word in the same cycle. Flash accesses are never abandoned. A flash programming event clears every line and the buffer once the access in flight has finished. Double-bit error status delivered with a line is kept with it and reported as a bus error. Single-bit correction status is reported as a one-cycle event.

Top module: `flash_prefetch_buf`

## Requirements
- R1: A request whose address matches a valid line gets `resp_valid_o` in the same cycle it is presented. The response is the 32-bit word chosen by address bits 3:2. Request addresses are word aligned.
- R2: Matching compares physical address bits 31:4 only, so any requester kind hits a line filled by another kind. No two valid lines hold the same tag.
- R3: On a miss with the flash idle, `fl_en_o` is high for exactly `wait_states_i`+1 cycles, starting the cycle after the request. The response arrives `wait_states_i`+2 cycles after the request was first presented.
- R4: The slot a fill replaces depends on `req_kind_i`. 0 (instruction) uses slot 0 and 1 (CPU data) uses slot 1. Kinds 2 and 3 (peripheral) alternate between slots 2 and 3, starting with slot 2 after reset.
- R5: A line fill, whether from flash or from the prefetch buffer, is followed by a prefetch only if `pf_mode_i` allows that fill's kind. 00 allows none, 01 allows kind 0, 10 allows kinds 0 and 1, and 11 allows all kinds.
- R6: A prefetch reads the line address one above the filled line. It starts in the first cycle the flash is idle, which is the cycle after a flash fill completes.
- R7: A request that misses all lines but matches a valid prefetch buffer is answered in the same cycle. The buffer contents move into the kind's slot.
- R8: A flash access, prefetch or demand, always runs to completion with its line address held. A miss during an access starts its own access only in the cycle after that access ends.
- R9: A one-cycle pulse on `prog_event_i` invalidates every line and the prefetch buffer in the first cycle the flash is idle after the pulse. No access starts in that cycle.
- R10: Reset clears all valid bits, tags and the prefetch buffer. It also leaves the flash port idle.
- R11: A response from a line whose fill carried `fl_ded_i` raises `resp_err_o` together with `resp_valid_o`.
- R12: `sec_event_o` pulses for one cycle when a flash fill completes with `fl_sec_i` set. It also pulses when a buffer whose prefetch carried `fl_sec_i` is moved into a line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wait_states_i | input | 3 | Flash wait states, 0 to 7 |
| pf_mode_i | input | 2 | Prefetch enable by requester kind |
| prog_event_i | input | 1 | Flash programming event pulse |
| req_valid_i | input | 1 | Read request, held until response |
| req_kind_i | input | 2 | 0 instruction, 1 CPU data, 2/3 peripheral |
| req_addr_i | input | 32 | Physical byte address, word aligned |
| resp_valid_o | output | 1 | Response this cycle |
| resp_data_o | output | 32 | Read word |
| resp_err_o | output | 1 | Bus error (double-bit error line) |
| sec_event_o | output | 1 | Single-bit correction event |
| fl_en_o | output | 1 | Flash access in progress |
| fl_line_o | output | 28 | Flash line address (bits 31:4) |
| fl_data_i | input | 128 | Flash line data, valid on the last access cycle |
| fl_sec_i | input | 1 | Single-bit corrected flag for the read |
| fl_ded_i | input | 1 | Double-bit error flag for the read |

## Verification
The bench model predicts each output separately for every cycle, and the outputs are compared away from the clock edge. A hit or a prefetch-buffer promotion must answer in the cycle of the request. A flash access must show up on the flash port one cycle after the decision that starts it and stay there for exactly wait-states+1 cycles. A demand fill is answered one cycle after the access ends. Directed reads measure the latency in cycles, for example 5 at three wait states and 16 when a miss queues behind a seven-wait-state prefetch. They also confirm that the prefetch address appears on the cycle after the response.

// File: rtl/pfb_pkg.sv
package pfb_pkg;
  localparam int unsigned N_LINES = 4;

  typedef enum logic [1:0] {
    KIND_INSTR  = 2'd0,
    KIND_DATA   = 2'd1,
    KIND_PERIPH = 2'd2
  } req_kind_e;

  function automatic logic pf_allowed(input logic [1:0] mode, input logic [1:0] kind);
    case (mode)
      2'b00:   pf_allowed = 1'b0;
      2'b01:   pf_allowed = (kind == KIND_INSTR);
      2'b10:   pf_allowed = (kind == KIND_INSTR) || (kind == KIND_DATA);
      default: pf_allowed = 1'b1;
    endcase
  endfunction

  function automatic logic [1:0] victim_slot(input logic [1:0] kind, input logic tog);
    if (kind == KIND_INSTR)     victim_slot = 2'd0;
    else if (kind == KIND_DATA) victim_slot = 2'd1;
    else                        victim_slot = {1'b1, tog};
  endfunction
endpackage

// File: rtl/pfb_flash_seq.sv
module pfb_flash_seq #(
  parameter int unsigned TAG_W = 28,
  parameter int unsigned WS_W  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WS_W-1:0]  ws_i,
  input  logic             start_i,
  input  logic             start_pf_i,
  input  logic [TAG_W-1:0] start_tag_i,
  input  logic [1:0]       start_kind_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [TAG_W-1:0] tag_o,
  output logic             pf_o,
  output logic [1:0]       kind_o
);
  logic            busy_q, pf_q;
  logic [WS_W-1:0] cnt_q;
  logic [TAG_W-1:0] tag_q;
  logic [1:0]      kind_q;

  assign done_o = busy_q && (cnt_q == ws_i);
  assign busy_o = busy_q;
  assign tag_o  = tag_q;
  assign pf_o   = pf_q;
  assign kind_o = kind_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      tag_q  <= '0;
      pf_q   <= 1'b0;
      kind_q <= '0;
    end else if (busy_q) begin
      if (done_o) busy_q <= 1'b0;
      else        cnt_q  <= cnt_q + 1'b1;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      tag_q  <= start_tag_i;
      pf_q   <= start_pf_i;
      kind_q <= start_kind_i;
    end
  end

  AST_ACCESS_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && $past(busy_q)) |-> $stable(tag_q)); // R8
  AST_CNT_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (cnt_q <= ws_i)); // R3
endmodule

// File: rtl/pfb_lines.sv
module pfb_lines #(
  parameter int unsigned N     = 4,
  parameter int unsigned TAG_W = 28,
  parameter int unsigned LINE_W = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TAG_W-1:0]  lookup_tag_i,
  input  logic              wr_en_i,
  input  logic [$clog2(N)-1:0] wr_idx_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic [1:0]        wr_type_i,
  input  logic [LINE_W-1:0] wr_data_i,
  input  logic              wr_ded_i,
  input  logic              inv_all_i,
  output logic              hit_o,
  output logic [N-1:0]      hit_vec_o,
  output logic [LINE_W-1:0] rd_data_o,
  output logic              rd_ded_o
);
  logic [N-1:0]      valid_q, ded_q;
  logic [TAG_W-1:0]  tag_q  [N];
  logic [1:0]        type_q [N];
  logic [LINE_W-1:0] data_q [N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      ded_q   <= '0;
      for (int i = 0; i < int'(N); i++) begin
        tag_q[i]  <= '0;
        type_q[i] <= '0;
        data_q[i] <= '0;
      end
    end else begin
      if (wr_en_i) begin
        valid_q[wr_idx_i] <= 1'b1;
        ded_q[wr_idx_i]   <= wr_ded_i;
        tag_q[wr_idx_i]   <= wr_tag_i;
        type_q[wr_idx_i]  <= wr_type_i;
        data_q[wr_idx_i]  <= wr_data_i;
      end
      if (inv_all_i) valid_q <= '0;
    end
  end

  for (genvar g = 0; g < int'(N); g++) begin : g_match
    assign hit_vec_o[g] = valid_q[g] && (tag_q[g] == lookup_tag_i);
  end

  always_comb begin
    rd_data_o = '0;
    rd_ded_o  = 1'b0;
    for (int i = 0; i < int'(N); i++) begin
      if (hit_vec_o[i]) begin
        rd_data_o = rd_data_o | data_q[i];
        rd_ded_o  = rd_ded_o | ded_q[i];
      end
    end
  end
  assign hit_o = |hit_vec_o;

  AST_SLOT0_INSTR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q[0] |-> (type_q[0] == 2'd0)); // R4
endmodule

// File: rtl/flash_prefetch_buf.sv
module flash_prefetch_buf
  import pfb_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LINE_BYTES = 16,
  parameter int unsigned WORD_W     = 32,
  parameter int unsigned WS_W       = 3
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic [WS_W-1:0]                       wait_states_i,
  input  logic [1:0]                            pf_mode_i,
  input  logic                                  prog_event_i,
  input  logic                                  req_valid_i,
  input  logic [1:0]                            req_kind_i,
  input  logic [ADDR_W-1:0]                     req_addr_i,
  output logic                                  resp_valid_o,
  output logic [WORD_W-1:0]                     resp_data_o,
  output logic                                  resp_err_o,
  output logic                                  sec_event_o,
  output logic                                  fl_en_o,
  output logic [ADDR_W-$clog2(LINE_BYTES)-1:0]  fl_line_o,
  input  logic [LINE_BYTES*8-1:0]               fl_data_i,
  input  logic                                  fl_sec_i,
  input  logic                                  fl_ded_i
);
  localparam int unsigned OFF_W  = $clog2(LINE_BYTES);
  localparam int unsigned TAG_W  = ADDR_W - OFF_W;
  localparam int unsigned LINE_W = LINE_BYTES * 8;
  localparam int unsigned WSEL_W = $clog2(LINE_W / WORD_W);
  localparam int unsigned IDX_W  = $clog2(N_LINES);

  logic [TAG_W-1:0]  req_tag;
  logic [WSEL_W-1:0] wsel;
  assign req_tag = req_addr_i[ADDR_W-1:OFF_W];
  assign wsel    = req_addr_i[OFF_W-1 -: WSEL_W];

  logic              line_hit, line_ded;
  logic [N_LINES-1:0] hit_vec;
  logic [LINE_W-1:0] line_data;

  logic              pfb_valid_q, pfb_ded_q, pfb_sec_q;
  logic [TAG_W-1:0]  pfb_tag_q;
  logic [LINE_W-1:0] pfb_data_q;

  logic              seq_busy, seq_done, seq_pf;
  logic [TAG_W-1:0]  seq_tag;
  logic [1:0]        seq_kind;

  logic              pf_pend_q, inv_pend_q, tog_q;
  logic [TAG_W-1:0]  pf_tag_q;

  logic pf_hit, miss, inv_do, start, fill_dem, fill_pf, wr_en, pp_set;
  logic [1:0]        wr_kind;
  logic [IDX_W-1:0]  wr_idx;
  logic [TAG_W-1:0]  wr_tag;
  logic [LINE_W-1:0] wr_data, sel_line;
  logic              wr_ded;

  assign pf_hit   = req_valid_i && !line_hit && pfb_valid_q && (pfb_tag_q == req_tag);
  assign miss     = req_valid_i && !line_hit && !pf_hit;
  assign inv_do   = inv_pend_q && !seq_busy;
  assign start    = !seq_busy && !inv_pend_q && (pf_pend_q || miss);
  assign fill_dem = seq_done && !seq_pf;
  assign fill_pf  = seq_done && seq_pf;

  // demand fill and promotion never coincide: one request is outstanding at a time
  assign wr_en   = fill_dem || pf_hit;
  assign wr_kind = fill_dem ? seq_kind : req_kind_i;
  assign wr_idx  = victim_slot(wr_kind, tog_q);
  assign wr_tag  = fill_dem ? seq_tag : pfb_tag_q;
  assign wr_data = fill_dem ? fl_data_i : pfb_data_q;
  assign wr_ded  = fill_dem ? fl_ded_i : pfb_ded_q;
  assign pp_set  = wr_en && pf_allowed(pf_mode_i, wr_kind);

  pfb_flash_seq #(.TAG_W(TAG_W), .WS_W(WS_W)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ws_i         (wait_states_i),
    .start_i      (start),
    .start_pf_i   (pf_pend_q),
    .start_tag_i  (pf_pend_q ? pf_tag_q : req_tag),
    .start_kind_i (req_kind_i),
    .busy_o       (seq_busy),
    .done_o       (seq_done),
    .tag_o        (seq_tag),
    .pf_o         (seq_pf),
    .kind_o       (seq_kind)
  );

  pfb_lines #(.N(N_LINES), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_lines (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .lookup_tag_i (req_tag),
    .wr_en_i      (wr_en),
    .wr_idx_i     (wr_idx),
    .wr_tag_i     (wr_tag),
    .wr_type_i    (wr_kind),
    .wr_data_i    (wr_data),
    .wr_ded_i     (wr_ded),
    .inv_all_i    (inv_do),
    .hit_o        (line_hit),
    .hit_vec_o    (hit_vec),
    .rd_data_o    (line_data),
    .rd_ded_o     (line_ded)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pfb_valid_q <= 1'b0;
      pfb_ded_q   <= 1'b0;
      pfb_sec_q   <= 1'b0;
      pfb_tag_q   <= '0;
      pfb_data_q  <= '0;
      pf_pend_q   <= 1'b0;
      pf_tag_q    <= '0;
      inv_pend_q  <= 1'b0;
      tog_q       <= 1'b0;
    end else begin
      if (inv_do)       pfb_valid_q <= 1'b0;
      else if (fill_pf) pfb_valid_q <= 1'b1;
      else if (pf_hit)  pfb_valid_q <= 1'b0;
      if (fill_pf) begin
        pfb_tag_q  <= seq_tag;
        pfb_data_q <= fl_data_i;
        pfb_ded_q  <= fl_ded_i;
        pfb_sec_q  <= fl_sec_i;
      end

      if (inv_do)                     pf_pend_q <= 1'b0;
      else if (pp_set)                pf_pend_q <= 1'b1;
      else if (start && pf_pend_q)    pf_pend_q <= 1'b0;
      if (pp_set) pf_tag_q <= wr_tag + TAG_W'(1);

      if (prog_event_i) inv_pend_q <= 1'b1;
      else if (inv_do)  inv_pend_q <= 1'b0;

      if (wr_en && wr_kind[1]) tog_q <= ~tog_q;
    end
  end

  assign sel_line     = pf_hit ? pfb_data_q : line_data;
  assign resp_valid_o = req_valid_i && (line_hit || pf_hit);
  assign resp_data_o  = sel_line[wsel*WORD_W +: WORD_W];
  assign resp_err_o   = resp_valid_o && (pf_hit ? pfb_ded_q : line_ded);
  assign sec_event_o  = (fill_dem && fl_sec_i) || (pf_hit && pfb_sec_q);
  assign fl_en_o      = seq_busy;
  assign fl_line_o    = seq_tag;

  AST_RESP_HAS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> req_valid_i); // R1
  AST_WORD_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |-> (req_addr_i[1:0] == 2'b00)); // R1
  AST_TAG_UNIQUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec)); // R2
  AST_ERR_WITH_RESP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_err_o |-> resp_valid_o); // R11
endmodule

// File: tb/tb_flash_prefetch_buf.sv
`timescale 1ns/1ps
module tb_flash_prefetch_buf;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [2:0]   ws = 3'd3;
  logic [1:0]   mode = 2'd0;
  logic         prog = 1'b0, req_valid = 1'b0;
  logic [1:0]   kind = 2'd0;
  logic [31:0]  addr = '0;
  logic         resp_valid, resp_err, sec_ev, fl_en;
  logic [31:0]  resp_data;
  logic [27:0]  fl_line;
  logic [127:0] fl_data;
  logic         fl_sec, fl_ded;

  int vectors = 0, fails = 0, sec_seen = 0;
  bit finished = 0;

  function automatic logic [127:0] fdata(input logic [27:0] t);
    logic [127:0] d;
    for (int k = 0; k < 4; k++) d[k*32 +: 32] = {t, 2'(k), 2'b00} ^ 32'h3C3C_0000;
    return d;
  endfunction
  function automatic logic fded(input logic [27:0] t); return t[7:0] == 8'h3D; endfunction
  function automatic logic fsec(input logic [27:0] t); return t[7:0] == 8'h21; endfunction
  function automatic logic allow(input logic [1:0] m, input logic [1:0] k);
    return (m == 2'd3) || (m == 2'd2 && k <= 2'd1) || (m == 2'd1 && k == 2'd0);
  endfunction

  assign fl_data = fdata(fl_line);
  assign fl_sec  = fsec(fl_line);
  assign fl_ded  = fded(fl_line);

  flash_prefetch_buf dut (
    .clk_i(clk), .rst_ni(rst_n), .wait_states_i(ws), .pf_mode_i(mode),
    .prog_event_i(prog), .req_valid_i(req_valid), .req_kind_i(kind), .req_addr_i(addr),
    .resp_valid_o(resp_valid), .resp_data_o(resp_data), .resp_err_o(resp_err),
    .sec_event_o(sec_ev), .fl_en_o(fl_en), .fl_line_o(fl_line),
    .fl_data_i(fl_data), .fl_sec_i(fl_sec), .fl_ded_i(fl_ded));

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic        mlv [4];
  logic [27:0] mlt [4];
  logic        mpv, mbusy, mcpf, mpp, mip, mtog;
  logic [27:0] mpt, mct, mppt;
  logic [1:0]  mck;
  int          mcnt;

  logic [27:0] rtag;
  logic        m_hit, m_pfh, m_miss, m_done;
  always_comb begin
    rtag  = addr[31:4];
    m_hit = 1'b0;
    for (int i = 0; i < 4; i++) if (mlv[i] && mlt[i] == rtag) m_hit = 1'b1;
    m_pfh  = req_valid && !m_hit && mpv && (mpt == rtag);
    m_miss = req_valid && !m_hit && !m_pfh;
    m_done = mbusy && (mcnt == int'(ws));
  end

  function automatic int slot(input logic [1:0] k, input logic t);
    return (k == 2'd0) ? 0 : (k == 2'd1) ? 1 : (t ? 3 : 2);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin mlv[i] = 1'b0; mlt[i] = '0; end
      mpv = 0; mbusy = 0; mcpf = 0; mpp = 0; mip = 0; mtog = 0;
      mpt = '0; mct = '0; mppt = '0; mck = '0; mcnt = 0;
    end else begin
      automatic logic d = m_done, pf = m_pfh, ms = m_miss, pp0 = mpp, ip0 = mip, b0 = mbusy;
      automatic logic [27:0] ppt0 = mppt;
      automatic bit setp = 0;
      if (d && !mcpf) begin
        mlv[slot(mck, mtog)] = 1; mlt[slot(mck, mtog)] = mct;
        if (allow(mode, mck)) begin setp = 1; mppt = mct + 1; end
        if (mck[1]) mtog = ~mtog;
      end else if (pf) begin
        mlv[slot(kind, mtog)] = 1; mlt[slot(kind, mtog)] = mpt;
        mpv = 0;
        if (allow(mode, kind)) begin setp = 1; mppt = rtag + 1; end
        if (kind[1]) mtog = ~mtog;
      end
      if (d && mcpf) begin mpv = 1; mpt = mct; end
      if (b0) begin
        if (d) mbusy = 0; else mcnt++;
      end else if (ip0) begin
        for (int i = 0; i < 4; i++) mlv[i] = 0;
        mpv = 0; mip = 0; setp = 0; mpp = 0;
      end else if (pp0 || ms) begin
        mbusy = 1; mcnt = 0; mcpf = pp0; mck = kind;
        mct = pp0 ? ppt0 : rtag;
        if (pp0) mpp = 0;
      end
      if (setp) mpp = 1;
      if (prog) mip = 1;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      automatic logic e_resp = req_valid && (m_hit || m_pfh);
      automatic logic [31:0] e_data = fdata(rtag)[addr[3:2]*32 +: 32];
      automatic logic e_sec = (m_done && !mcpf && fsec(mct)) || (m_pfh && fsec(mpt));
      check(resp_valid == e_resp, "R1 resp_valid", resp_valid, e_resp);
      if (e_resp) begin
        check(resp_data == e_data, "R1 resp_data", resp_data, e_data);
        check(resp_err == fded(rtag), "R11 resp_err", resp_err, fded(rtag));
      end
      check(sec_ev == e_sec, "R12 sec_event", sec_ev, e_sec);
      check(fl_en == mbusy, "R3 fl_en", fl_en, mbusy);
      if (mbusy) check(fl_line == mct, "R6 fl_line", fl_line, mct);
      if (sec_ev) sec_seen++;
    end
  end

  task automatic rd(input logic [1:0] k, input logic [31:0] a, output int lat,
                    output logic [31:0] dat, output logic er);
    @(posedge clk); #1;
    req_valid = 1; kind = k; addr = a; lat = 0;
    @(negedge clk);
    while (!resp_valid && lat < 100) begin lat++; @(negedge clk); end
    dat = resp_data; er = resp_err;
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int lat, s0;
    logic [31:0] dat;
    logic er;
    @(negedge clk);
    check(resp_valid == 0 && fl_en == 0, "R10 reset outputs", {resp_valid, fl_en}, 0);
    idle(2);
    rst_n = 1;

    // R10 / R3: first access after reset misses, ws=3 -> 5 cycles
    rd(2'd0, 32'h0000_1000, lat, dat, er);
    check(lat == 5, "R3 R10 miss latency ws3", lat, 5);
    check(dat == (32'h0000_1000 ^ 32'h3C3C_0000), "R1 miss data", dat, 32'h0000_1000 ^ 32'h3C3C_0000);
    @(negedge clk);
    check(fl_en == 0, "R5 mode 00 no prefetch", fl_en, 0);
    rd(2'd0, 32'h0000_1004, lat, dat, er);
    check(lat == 0, "R1 hit zero wait", lat, 0);
    rd(2'd2, 32'h0000_1008, lat, dat, er);
    check(lat == 0, "R2 peripheral hits instr slot", lat, 0);

    // R6 / R7: instruction prefetch
    mode = 2'd1;
    rd(2'd0, 32'h0000_2000, lat, dat, er);
    check(lat == 5, "R3 miss latency", lat, 5);
    @(negedge clk);
    check(fl_en == 1, "R6 prefetch starts", fl_en, 1);
    check(fl_line == 28'h201, "R6 prefetch next line", fl_line, 28'h201);
    idle(6);
    rd(2'd0, 32'h0000_201C, lat, dat, er);
    check(lat == 0, "R7 promotion same cycle", lat, 0);
    check(dat == (32'h0000_201C ^ 32'h3C3C_0000), "R7 promoted data", dat, 32'h0000_201C ^ 32'h3C3C_0000);
    rd(2'd0, 32'h0000_2014, lat, dat, er);
    check(lat == 0, "R7 promoted line hit", lat, 0);

    // R5: mode 01 does not prefetch after CPU data fill
    idle(12);
    rd(2'd1, 32'h0000_3000, lat, dat, er);
    check(lat == 5, "R3 data miss", lat, 5);
    @(negedge clk);
    check(fl_en == 0, "R5 data not prefetched in mode 01", fl_en, 0);

    // R8: miss queued behind a 7-wait-state prefetch
    mode = 2'd3; ws = 3'd7;
    rd(2'd2, 32'h0000_4000, lat, dat, er);
    check(lat == 9, "R3 ws7 latency", lat, 9);
    rd(2'd2, 32'h0000_5000, lat, dat, er);
    check(lat == 16, "R8 miss waits for prefetch", lat, 16);

    // R4: peripheral slots alternate 2,3,2
    idle(12);
    rd(2'd3, 32'h0000_4004, lat, dat, er);
    check(lat == 0, "R4 peripheral line kept", lat, 0);
    idle(12);
    rd(2'd2, 32'h0000_6000, lat, dat, er);
    check(lat > 0, "R4 new peripheral line misses", lat, 1);
    idle(12);
    rd(2'd2, 32'h0000_5008, lat, dat, er);
    check(lat == 0, "R4 slot 3 survives", lat, 0);
    idle(12);
    rd(2'd2, 32'h0000_4008, lat, dat, er);
    check(lat > 0, "R4 slot 2 evicted", lat, 1);

    // R11 / R12: error flags
    mode = 2'd0; idle(12);
    rd(2'd1, 32'h0000_03D0, lat, dat, er);
    check(er == 1, "R11 double-bit error line", er, 1);
    s0 = sec_seen;
    rd(2'd1, 32'h0000_0210, lat, dat, er);
    check(sec_seen == s0 + 1, "R12 single-bit event", sec_seen, s0 + 1);
    rd(2'd1, 32'h0000_0214, lat, dat, er);
    check(er == 0 && lat == 0, "R11 clean hit no error", {er, lat[7:0]}, 0);

    // R3 zero wait states
    ws = 3'd0; idle(12);
    rd(2'd0, 32'h0000_9000, lat, dat, er);
    check(lat == 2, "R3 ws0 latency", lat, 2);

    // R9: programming event during an access
    ws = 3'd7;
    fork
      rd(2'd0, 32'h0000_8000, lat, dat, er);
      begin idle(3); prog = 1; idle(1); prog = 0; end
    join
    check(lat == 9, "R9 access completes first", lat, 9);
    rd(2'd0, 32'h0000_8004, lat, dat, er);
    check(lat == 9, "R9 line invalidated", lat, 9);

    idle(4);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule